// File: doc/BRIEF.md
# SPI Byte FIFO Pair with Trigger Requests

This block sits between the register bus of an SPI host controller and its shift engine. It holds two byte-wide queues. Software or a DMA engine fills the transmit queue from the bus side and the shift engine drains it. The shift engine fills the receive queue and the bus side drains it. Both queues reveal their head byte before the pop is taken.

A 32-bit control word sets a separate trigger level for each direction. It also holds a DMA request enable for each direction and a soft flush bit for each queue. The receive side raises a ready flag once enough bytes have arrived, and that flag stays pending until software clears it. The transmit side raises a request while it has drained down to its level. Either condition can also drive a DMA request line. A packed status word reports both fill counts, together with a sticky overflow flag for bus pushes into a full transmit queue and a sticky underflow flag for bus pops from an empty receive queue.

Top module: `spi_fifo_trig`

## Requirements
- R1: Queue depth is the parameter DEPTH, a power of two from 2 to 128 (64 and 128 are the intended sizes). Status bits [7:0] give the receive fill count and bits [23:16] give the transmit fill count, each from 0 to DEPTH.
- R2: Control bits [7:0] hold the receive trigger level, bits [23:16] the transmit trigger level, bit 8 the receive DMA enable and bit 24 the transmit DMA enable. A control write stores all of them, and they read back at the same positions on `ctl_rdata`.
- R3: Each queue returns bytes in the order they were pushed. The head byte is visible on the read-data port while the queue is not empty.
- R4: Writing 1 to control bit 15 empties the receive queue, and writing 1 to control bit 31 empties the transmit queue, at the clock edge after the write. The flush also clears that queue's sticky flag and, on the receive side, the pending ready flag. The other queue is not touched. A flush wins over a push or pop in the same cycle.
- R5: The two flush bits clear themselves one cycle after the write and always read as 0.
- R6: A bus push into a full transmit queue is dropped and sets status bit 24. A bus pop from an empty receive queue returns 0 and sets status bit 8. Both flags stay set until that queue is flushed. An engine push into a full receive queue is also dropped, but it sets no flag.
- R7: `rx_ready` is high while the receive count is non-zero and at least the receive level. Once raised, it stays high until the count is below the level and `rx_rdy_ack` is pulsed. A pulse while the count is still at or above the level has no effect.
- R8: `tx_request` is high exactly while the transmit count is at or below the transmit level.
- R9: Each DMA request is the level condition of its direction (the R7 count condition without the pending hold, or the R8 condition) ANDed with that direction's DMA enable. It stays low whenever the enable is clear.
- R10: After reset both queues are empty, the control word is 0 and the status word is 0. `rx_ready` and both DMA requests are low, `tx_request` is high and `eng_tx_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback (flush bits read 0) |
| stat_word | output | 32 | Packed fill counts and sticky flags |
| rx_rdy_ack | input | 1 | Clears the pending receive ready flag |
| bus_tx_push | input | 1 | Bus-side push into the transmit queue |
| bus_tx_data | input | 8 | Byte to push into the transmit queue |
| bus_rx_pop | input | 1 | Bus-side pop from the receive queue |
| bus_rx_data | output | 8 | Receive queue head byte (0 when empty) |
| eng_tx_pop | input | 1 | Engine-side pop from the transmit queue |
| eng_tx_data | output | 8 | Transmit queue head byte (0 when empty) |
| eng_tx_empty | output | 1 | Transmit queue empty |
| eng_rx_push | input | 1 | Engine-side push into the receive queue |
| eng_rx_data | input | 8 | Byte to push into the receive queue |
| eng_rx_full | output | 1 | Receive queue full |
| rx_ready | output | 1 | Receive ready level flag for the interrupt controller |
| tx_request | output | 1 | Transmit empty-request level flag |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The embedded assertions check, on every cycle, that the fill count never exceeds the depth and that a flush leaves the queue empty. They also check that a push into a full queue or a pop from an empty queue leaves the count unchanged, that a raised receive ready flag holds until it is acknowledged, and that the flush bits clear themselves. Other behaviours can only be shown by the bench scenarios. These include byte ordering, that a dropped push does not corrupt stored data, and the exact fill levels at which each trigger flag and DMA request switches. The bench also shows the order of drain and acknowledge that releases the ready flag, the readback of the control fields, and that a flush leaves the other queue intact.

// File: rtl/spf_pkg.sv
package spf_pkg;

   // Field positions inside the control and status words
   localparam int FLD_W       = 8;
   localparam int RX_LVL_LSB  = 0;
   localparam int TX_LVL_LSB  = 16;
   localparam int RX_DMA_BIT  = 8;
   localparam int TX_DMA_BIT  = 24;
   localparam int RX_FLSH_BIT = 15;
   localparam int TX_FLSH_BIT = 31;
   localparam int RX_UNF_BIT  = 8;
   localparam int TX_OVF_BIT  = 24;

   typedef struct packed {
      logic [FLD_W-1:0] rx_lvl;
      logic [FLD_W-1:0] tx_lvl;
      logic             rx_dma_en;
      logic             tx_dma_en;
   } spf_cfg_t;

   typedef enum logic {
      TRIG_AT_OR_ABOVE = 1'b0,
      TRIG_AT_OR_BELOW = 1'b1
   } spf_trig_dir_e;

endpackage

// File: rtl/spf_byte_fifo.sv
module spf_byte_fifo #(
   parameter int DEPTH = 128,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty,
   output logic          push_drop,
   output logic          pop_miss
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spf_byte_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full      = (cnt_q == CW'(DEPTH));
   assign empty     = (cnt_q == '0);
   assign do_push   = push & ~full;
   assign do_pop    = pop & ~empty;
   assign push_drop = push & full;
   assign pop_miss  = pop & empty;
   assign count     = cnt_q;
   assign dout      = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= din;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH)); // R1
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0) && empty); // R4
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      push && full && !pop && !flush |=> cnt_q == $past(cnt_q)); // R6
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      pop && empty && !push && !flush |=> cnt_q == '0); // R6

endmodule

// File: rtl/spf_trigger.sv
module spf_trigger #(
   parameter int                    CW   = 8,
   parameter spf_pkg::spf_trig_dir_e DIR = spf_pkg::TRIG_AT_OR_ABOVE,
   parameter bit                    HOLD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   input  logic [7:0]    level,
   input  logic          dma_en,
   input  logic          ack,
   input  logic          flush,
   output logic          irq_flag,
   output logic          dma_req
);

   if (CW > 8) begin : g_bad_cw
      $error("spf_trigger: count must fit the 8-bit status field");
   end

   logic [8:0] cnt_x, lvl_x;
   logic       cond;

   assign cnt_x = 9'(count);
   assign lvl_x = {1'b0, level};

   if (DIR == spf_pkg::TRIG_AT_OR_ABOVE) begin : g_above
      assign cond = (cnt_x != '0) && (cnt_x >= lvl_x);
   end else begin : g_below
      assign cond = (cnt_x <= lvl_x);
   end

   assign dma_req = cond & dma_en;

   if (HOLD) begin : g_hold
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pend_q <= 1'b0;
         else if (flush)  pend_q <= 1'b0;
         else if (cond)   pend_q <= 1'b1;
         else if (ack)    pend_q <= 1'b0;
      end
      assign irq_flag = cond | pend_q;

      AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         irq_flag && !ack && !flush |=> irq_flag); // R7
   end else begin : g_level
      logic unused_hold;
      assign unused_hold = ack ^ flush ^ clk ^ rst_n;
      assign irq_flag    = cond;
   end

endmodule

// File: rtl/spf_ctrl_regs.sv
module spf_ctrl_regs
   import spf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output spf_cfg_t    cfg,
   output logic        rx_flush,
   output logic        tx_flush,
   output logic [31:0] rdata
);

   spf_cfg_t cfg_q;
   logic     rx_fl_q, tx_fl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         rx_fl_q <= 1'b0;
         tx_fl_q <= 1'b0;
      end else begin
         rx_fl_q <= wr_en & wdata[RX_FLSH_BIT];
         tx_fl_q <= wr_en & wdata[TX_FLSH_BIT];
         if (wr_en) begin
            cfg_q.rx_lvl    <= wdata[RX_LVL_LSB +: FLD_W];
            cfg_q.tx_lvl    <= wdata[TX_LVL_LSB +: FLD_W];
            cfg_q.rx_dma_en <= wdata[RX_DMA_BIT];
            cfg_q.tx_dma_en <= wdata[TX_DMA_BIT];
         end
      end
   end

   always_comb begin
      rdata                         = '0;
      rdata[RX_LVL_LSB +: FLD_W]    = cfg_q.rx_lvl;
      rdata[TX_LVL_LSB +: FLD_W]    = cfg_q.tx_lvl;
      rdata[RX_DMA_BIT]             = cfg_q.rx_dma_en;
      rdata[TX_DMA_BIT]             = cfg_q.tx_dma_en;
   end

   assign cfg      = cfg_q;
   assign rx_flush = rx_fl_q;
   assign tx_flush = tx_fl_q;

   AST_FLUSH_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fl_q && !(wr_en && wdata[RX_FLSH_BIT]) |=> !rx_fl_q); // R5

endmodule

// File: rtl/spi_fifo_trig.sv
module spi_fifo_trig
   import spf_pkg::*;
#(
   parameter int DEPTH = 128,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_wr,
   input  logic [31:0] ctl_wdata,
   output logic [31:0] ctl_rdata,
   output logic [31:0] stat_word,
   input  logic        rx_rdy_ack,
   input  logic        bus_tx_push,
   input  logic [7:0]  bus_tx_data,
   input  logic        bus_rx_pop,
   output logic [7:0]  bus_rx_data,
   input  logic        eng_tx_pop,
   output logic [7:0]  eng_tx_data,
   output logic        eng_tx_empty,
   input  logic        eng_rx_push,
   input  logic [7:0]  eng_rx_data,
   output logic        eng_rx_full,
   output logic        rx_ready,
   output logic        tx_request,
   output logic        rx_dma_req,
   output logic        tx_dma_req
);

   if (DEPTH > 128) begin : g_bad_depth
      $error("spi_fifo_trig: DEPTH above 128 does not fit the status field");
   end

   localparam int NDIR = 2;   // index 0 = receive, 1 = transmit

   spf_cfg_t cfg;
   logic     rx_flush, tx_flush;

   spf_ctrl_regs u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ctl_wr),
      .wdata    (ctl_wdata),
      .cfg      (cfg),
      .rx_flush (rx_flush),
      .tx_flush (tx_flush),
      .rdata    (ctl_rdata)
   );

   logic [NDIR-1:0] q_push, q_pop, q_flush, q_full, q_empty, q_drop, q_miss;
   logic [NDIR-1:0] q_dma_en, q_ack, q_flag, q_dreq;
   logic [7:0]      q_din [NDIR];
   logic [7:0]      q_dout[NDIR];
   logic [7:0]      q_lvl [NDIR];
   logic [CW-1:0]   q_cnt [NDIR];

   assign q_push  = {bus_tx_push, eng_rx_push};
   assign q_pop   = {eng_tx_pop, bus_rx_pop};
   assign q_flush = {tx_flush, rx_flush};
   assign q_din[0] = eng_rx_data;
   assign q_din[1] = bus_tx_data;
   assign q_lvl[0] = cfg.rx_lvl;
   assign q_lvl[1] = cfg.tx_lvl;
   assign q_dma_en = {cfg.tx_dma_en, cfg.rx_dma_en};
   assign q_ack    = {1'b0, rx_rdy_ack};

   for (genvar gi = 0; gi < NDIR; gi++) begin : g_dir
      spf_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (q_flush[gi]),
         .push      (q_push[gi]),
         .din       (q_din[gi]),
         .pop       (q_pop[gi]),
         .dout      (q_dout[gi]),
         .count     (q_cnt[gi]),
         .full      (q_full[gi]),
         .empty     (q_empty[gi]),
         .push_drop (q_drop[gi]),
         .pop_miss  (q_miss[gi])
      );

      spf_trigger #(
         .CW   (CW),
         .DIR  ((gi == 0) ? TRIG_AT_OR_ABOVE : TRIG_AT_OR_BELOW),
         .HOLD (gi == 0)
      ) u_trig (
         .clk      (clk),
         .rst_n    (rst_n),
         .count    (q_cnt[gi]),
         .level    (q_lvl[gi]),
         .dma_en   (q_dma_en[gi]),
         .ack      (q_ack[gi]),
         .flush    (q_flush[gi]),
         .irq_flag (q_flag[gi]),
         .dma_req  (q_dreq[gi])
      );
   end

   // Sticky error flags, bus side only
   logic rx_unf_q, tx_ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_unf_q <= 1'b0;
         tx_ovf_q <= 1'b0;
      end else begin
         if (rx_flush)       rx_unf_q <= 1'b0;
         else if (q_miss[0]) rx_unf_q <= 1'b1;
         if (tx_flush)       tx_ovf_q <= 1'b0;
         else if (q_drop[1]) tx_ovf_q <= 1'b1;
      end
   end

   always_comb begin
      stat_word                    = '0;
      stat_word[7:0]               = 8'(q_cnt[0]);
      stat_word[23:16]             = 8'(q_cnt[1]);
      stat_word[RX_UNF_BIT]        = rx_unf_q;
      stat_word[TX_OVF_BIT]        = tx_ovf_q;
   end

   logic unused_sides;
   assign unused_sides = q_drop[0] ^ q_miss[1] ^ q_full[1] ^ q_empty[0];

   assign bus_rx_data  = q_dout[0];
   assign eng_tx_data  = q_dout[1];
   assign eng_tx_empty = q_empty[1];
   assign eng_rx_full  = q_full[0];
   assign rx_ready     = q_flag[0];
   assign tx_request   = q_flag[1];
   assign rx_dma_req   = q_dreq[0];
   assign tx_dma_req   = q_dreq[1];

endmodule

// File: tb/spi_fifo_trig_test.sv
module spi_fifo_trig_test;

   localparam int DEPTH = 128;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ctl_wr;
   logic [31:0] ctl_wdata;
   logic [31:0] ctl_rdata;
   logic [31:0] stat_word;
   logic        rx_rdy_ack;
   logic        bus_tx_push;
   logic [7:0]  bus_tx_data;
   logic        bus_rx_pop;
   logic [7:0]  bus_rx_data;
   logic        eng_tx_pop;
   logic [7:0]  eng_tx_data;
   logic        eng_tx_empty;
   logic        eng_rx_push;
   logic [7:0]  eng_rx_data;
   logic        eng_rx_full;
   logic        rx_ready, tx_request, rx_dma_req, tx_dma_req;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   spi_fifo_trig #(.DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .stat_word(stat_word), .rx_rdy_ack(rx_rdy_ack),
      .bus_tx_push(bus_tx_push), .bus_tx_data(bus_tx_data),
      .bus_rx_pop(bus_rx_pop), .bus_rx_data(bus_rx_data),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_tx_empty(eng_tx_empty),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
      .eng_rx_full(eng_rx_full),
      .rx_ready(rx_ready), .tx_request(tx_request),
      .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ctl_write(input logic [31:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      cyc();
      ctl_wr = 1'b0; ctl_wdata = '0;
   endtask

   task automatic tx_push(input logic [7:0] b);
      bus_tx_push = 1'b1; bus_tx_data = b;
      cyc();
      bus_tx_push = 1'b0;
   endtask

   task automatic tx_pop(output logic [7:0] b);
      b = eng_tx_data;
      eng_tx_pop = 1'b1;
      cyc();
      eng_tx_pop = 1'b0;
   endtask

   task automatic rx_push(input logic [7:0] b);
      eng_rx_push = 1'b1; eng_rx_data = b;
      cyc();
      eng_rx_push = 1'b0;
   endtask

   task automatic rx_pop(output logic [7:0] b);
      b = bus_rx_data;
      bus_rx_pop = 1'b1;
      cyc();
      bus_rx_pop = 1'b0;
   endtask

   task automatic t_reset_state();
      chk("R10 status", stat_word, 32'h0);
      chk("R10 control", ctl_rdata, 32'h0);
      chk("R10 rx_ready", {31'b0, rx_ready}, 32'd0);
      chk("R10 tx_request", {31'b0, tx_request}, 32'd1);
      chk("R10 dma reqs", {30'b0, rx_dma_req, tx_dma_req}, 32'd0);
      chk("R10 tx empty", {31'b0, eng_tx_empty}, 32'd1);
   endtask

   task automatic t_ctrl_fields();
      ctl_write(32'h8118_8105);
      chk("R2 R5 readback", ctl_rdata, 32'h0118_0105);
      cyc();
      chk("R5 flush bits read 0 later", ctl_rdata, 32'h0118_0105);
      ctl_write(32'h0);
   endtask

   task automatic t_tx_order();
      logic [7:0] b;
      tx_push(8'hA1); tx_push(8'hB2); tx_push(8'hC3);
      chk("R1 tx count", {24'b0, stat_word[23:16]}, 32'd3);
      tx_pop(b); chk("R3 tx byte 0", {24'b0, b}, 32'hA1);
      tx_pop(b); chk("R3 tx byte 1", {24'b0, b}, 32'hB2);
      tx_pop(b); chk("R3 tx byte 2", {24'b0, b}, 32'hC3);
      chk("R1 tx count drained", stat_word, 32'h0);
   endtask

   task automatic t_rx_trigger();
      logic [7:0] b;
      ctl_write(32'h0000_0104);
      rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
      chk("R7 below level", {31'b0, rx_ready}, 32'd0);
      chk("R9 rx dma below", {31'b0, rx_dma_req}, 32'd0);
      rx_push(8'h44);
      chk("R7 at level", {31'b0, rx_ready}, 32'd1);
      chk("R9 rx dma at level", {31'b0, rx_dma_req}, 32'd1);
      chk("R1 rx count", {24'b0, stat_word[7:0]}, 32'd4);
      rx_rdy_ack = 1'b1; cyc(); rx_rdy_ack = 1'b0;
      chk("R7 ack above level ignored", {31'b0, rx_ready}, 32'd1);
      rx_pop(b); chk("R3 rx byte 0", {24'b0, b}, 32'h11);
      chk("R7 pending after drain", {31'b0, rx_ready}, 32'd1);
      chk("R9 rx dma follows level", {31'b0, rx_dma_req}, 32'd0);
      rx_rdy_ack = 1'b1; cyc(); rx_rdy_ack = 1'b0;
      chk("R7 cleared after drain and ack", {31'b0, rx_ready}, 32'd0);
      rx_pop(b); chk("R3 rx byte 1", {24'b0, b}, 32'h22);
      rx_pop(b); chk("R3 rx byte 2", {24'b0, b}, 32'h33);
      rx_pop(b); chk("R3 rx byte 3", {24'b0, b}, 32'h44);
   endtask

   task automatic t_tx_trigger();
      logic [7:0] b;
      ctl_write(32'h0102_0000);
      chk("R8 empty at level", {31'b0, tx_request}, 32'd1);
      chk("R9 tx dma enabled", {31'b0, tx_dma_req}, 32'd1);
      tx_push(8'h01); tx_push(8'h02); tx_push(8'h03);
      chk("R8 above level", {31'b0, tx_request}, 32'd0);
      chk("R9 tx dma above", {31'b0, tx_dma_req}, 32'd0);
      tx_pop(b);
      chk("R8 at level after pop", {31'b0, tx_request}, 32'd1);
      chk("R9 tx dma at level", {31'b0, tx_dma_req}, 32'd1);
      ctl_write(32'h0002_0000);
      chk("R9 tx dma disabled", {31'b0, tx_dma_req}, 32'd0);
      chk("R8 request kept", {31'b0, tx_request}, 32'd1);
      ctl_write(32'h8002_0000);
      cyc();
      chk("R4 tx flush", {24'b0, stat_word[23:16]}, 32'd0);
      ctl_write(32'h0);
   endtask

   task automatic t_overflow();
      logic [7:0] b;
      for (int i = 0; i < DEPTH; i++) tx_push(8'(i));
      rx_push(8'h5A); rx_push(8'h6B);
      chk("R1 tx full count", {24'b0, stat_word[23:16]}, DEPTH);
      chk("R6 no overflow yet", {31'b0, stat_word[24]}, 32'd0);
      tx_push(8'hEE);
      chk("R6 overflow flag", {31'b0, stat_word[24]}, 32'd1);
      chk("R6 count unchanged", {24'b0, stat_word[23:16]}, DEPTH);
      tx_pop(b);
      chk("R6 dropped byte not stored", {24'b0, b}, 32'h00);
      chk("R6 overflow sticky", {31'b0, stat_word[24]}, 32'd1);
      ctl_write(32'h8000_0000);
      cyc();
      chk("R4 tx flushed", {24'b0, stat_word[23:16]}, 32'd0);
      chk("R4 overflow cleared", {31'b0, stat_word[24]}, 32'd0);
      chk("R4 rx untouched", {24'b0, stat_word[7:0]}, 32'd2);
      ctl_write(32'h0000_8000);
      cyc();
      chk("R4 rx flushed", stat_word, 32'h0);
   endtask

   task automatic t_underflow();
      logic [7:0] b;
      bus_rx_pop = 1'b1;
      chk("R6 empty pop data", {24'b0, bus_rx_data}, 32'h0);
      cyc();
      bus_rx_pop = 1'b0;
      chk("R6 underflow flag", {31'b0, stat_word[8]}, 32'd1);
      chk("R6 rx count stays 0", {24'b0, stat_word[7:0]}, 32'd0);
      rx_push(8'h77);
      rx_pop(b);
      chk("R3 rx after underflow", {24'b0, b}, 32'h77);
      chk("R6 underflow sticky", {31'b0, stat_word[8]}, 32'd1);
      ctl_write(32'h0000_8000);
      cyc();
      chk("R4 underflow cleared", {31'b0, stat_word[8]}, 32'd0);
   endtask

   task automatic t_selfclear();
      ctl_write(32'h0000_8000);
      chk("R5 reads 0", ctl_rdata, 32'h0);
      rx_push(8'h12);
      chk("R4 flush wins over push", {24'b0, stat_word[7:0]}, 32'd0);
      rx_push(8'h34);
      chk("R5 flush not repeated", {24'b0, stat_word[7:0]}, 32'd1);
      ctl_write(32'h0000_8000);
      cyc();
   endtask

   task automatic t_engine_full();
      logic [7:0] b;
      for (int i = 0; i < DEPTH; i++) rx_push(8'(i + 3));
      chk("R1 rx full flag", {31'b0, eng_rx_full}, 32'd1);
      rx_push(8'hFF);
      chk("R6 engine push dropped", {24'b0, stat_word[7:0]}, DEPTH);
      chk("R6 engine drop sets no flag", {31'b0, stat_word[8]}, 32'd0);
      rx_pop(b);
      chk("R6 head intact", {24'b0, b}, 32'h03);
      ctl_write(32'h0000_8000);
      cyc();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; rx_rdy_ack = 1'b0;
      bus_tx_push = 1'b0; bus_tx_data = '0; bus_rx_pop = 1'b0;
      eng_tx_pop = 1'b0; eng_rx_push = 1'b0; eng_rx_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc();
      t_reset_state();
      t_ctrl_fields();
      t_tx_order();
      t_rx_trigger();
      t_tx_trigger();
      t_overflow();
      t_underflow();
      t_selfclear();
      t_engine_full();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule